// File: doc/BRIEF.md
# SCSI Selection and Reselection Responder

This block watches the SCSI bus control lines and data byte to decide when the local device is being selected as a target by an initiator, or reselected as an initiator by a target. All bus inputs first pass through a two-flop synchronizer. A qualification must be seen on two consecutive synchronized samples before the block acts on it, so a single-cycle glitch is rejected.

On a qualified event the block captures the other device's 3-bit ID into a source ID register, together with a valid flag. It then drives BSY. For a selection it keeps BSY driven, waits for SEL to be released, and pulses a selected interrupt, with a bus-service interrupt on the same cycle when ATN was present. For a reselection it waits for SEL to be released, then drops BSY and pulses a reselected interrupt on the same edge. Either way the block then stays in its connected role and ignores further bus events until reset. Arbitration by the local device is not part of this block.

Top module: `scsi_sel_responder`

## Requirements
- R1: While `rst_n` is low on a rising edge, the block returns to idle: `bsy_out`=0, `src_id`=8'h07, all interrupt outputs 0.
- R2: A selection qualifies only when `sel_en`=1, `sel_out`=0, `bsy_in`=0, `sel_in`=1 and `io_in`=0. If any one of these conditions fails, the pattern is ignored.
- R3: A reselection qualifies only when `resel_en`=1, `sel_out`=0, `bsy_in`=0, `sel_in`=1 and `io_in`=1. If any one of these conditions fails, the pattern is ignored.
- R4: Both kinds of event also require two things. First, data bit `data_in[own_id]` must be 1. Second, parity must be odd, meaning the number of ones in `data_in` plus `parity_in` is odd.
- R5: Call the data bits other than the own bit "other bits". A selection accepts zero or one other bit. A reselection requires exactly one other bit. Any other count is ignored.
- R6: On an accepted event, `src_id` is loaded as follows: bits 2:0 hold the binary index of the other bit, bits 6:3 are 0, and bit 7 is the valid flag. The valid flag is 1 when an other bit was present, which is always the case for a reselection. A selection with no other bit loads 8'h00.
- R7: Inputs pass a two-flop synchronizer and must qualify on two consecutive samples. With inputs held stable before rising edge E0, `bsy_out` and `src_id` change on edge E3. A pattern held for only one clock cycle is ignored.
- R8: After a selection, `bsy_out` stays 1. The third rising edge after `sel_in` falls raises `irq_selected` for exactly one cycle. `irq_bus_service` pulses on that same cycle if and only if `atn_in` was 1 when the selection qualified.
- R9: After a reselection, the third rising edge after `sel_in` falls does two things together: it clears `bsy_out` and pulses `irq_reselected` for one cycle.
- R10: Once connected in either role, the block ignores any further qualifying patterns until reset. `src_id` and `bsy_out` keep their values and no interrupt is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sel_in | input | 1 | SEL line as seen on the bus |
| bsy_in | input | 1 | BSY line as seen on the bus |
| sel_out | input | 1 | Local device currently driving SEL |
| io_in | input | 1 | I/O line from the bus |
| atn_in | input | 1 | ATN line from the bus |
| data_in | input | 8 | Bus data byte |
| parity_in | input | 1 | Bus data parity (odd) |
| own_id | input | 3 | Local device ID |
| sel_en | input | 1 | Enables response to selection |
| resel_en | input | 1 | Enables response to reselection |
| bsy_out | output | 1 | Drive BSY on the bus |
| src_id | output | 8 | Captured ID of the other device, bit 7 = valid |
| irq_selected | output | 1 | One-cycle pulse: connected as target |
| irq_bus_service | output | 1 | One-cycle pulse with selection when ATN was present |
| irq_reselected | output | 1 | One-cycle pulse: connected as initiator |

## Verification
The assertions check several properties on every cycle:
- the two role interrupts never fire together;
- bus service only accompanies a selected pulse;
- every interrupt lasts one cycle;
- BSY is driven during a selected pulse and released during a reselected pulse;
- any rise of BSY was preceded by an enable;
- a reselection always leaves the valid flag set.

Some behaviour only the directed scenarios can show:
- exact qualification per input field, meaning parity, own bit and other-bit count;
- the precise edge latency through the synchronizers;
- glitch rejection;
- the encoded ID values;
- the fact that a connected block ignores later patterns.

// File: rtl/scsi_sel_pkg.sv
// Shared types and constants for the selection/reselection responder.
package scsi_sel_pkg;

    // Kind of bus event seen on one synchronized sample.
    typedef enum logic [1:0] {
        QK_NONE  = 2'd0,
        QK_SEL   = 2'd1,
        QK_RESEL = 2'd2
    } qual_kind_t;

    // Handshake sequencer states.
    typedef enum logic [2:0] {
        ST_IDLE       = 3'd0,
        ST_SEL_HOLD   = 3'd1,
        ST_RESEL_HOLD = 3'd2,
        ST_TARGET     = 3'd3,
        ST_INITIATOR  = 3'd4
    } hs_state_t;

    // Reset value of bits 2:0 of the source ID register.
    localparam logic [2:0] SRC_ID_RST_LOW = 3'b111;

endpackage

// File: rtl/scsi_bus_sync.sv
// Multi-stage synchronizer for a vector of asynchronous bus lines.
// Assumes each bit is independently sampled; skew between bits is
// covered downstream by the consecutive-sample qualification filter.
module scsi_bus_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_in,
    output logic [WIDTH-1:0] d_out
);

    logic [WIDTH-1:0] chain [STAGES];

    // Stage 0 samples the raw lines.
    always_ff @(posedge clk) begin
        if (!rst_n) chain[0] <= '0;
        else        chain[0] <= d_in;
    end

    // Remaining stages shift the sampled value along.
    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) chain[s] <= '0;
            else        chain[s] <= chain[s-1];
        end
    end

    assign d_out = chain[STAGES-1];

endmodule

// File: rtl/scsi_sel_qualifier.sv
// Decides, per synchronized sample, whether the bus shows a valid
// selection or reselection of this device, encodes the other device's
// ID, and requires the same kind on SAMPLES consecutive samples
// before reporting a hit. Assumes odd parity over the data byte.
module scsi_sel_qualifier
    import scsi_sel_pkg::*;
#(
    parameter int ID_W    = 3,
    parameter int SAMPLES = 2,
    localparam int DATA_W = 1 << ID_W,
    localparam int CNT_W  = $clog2(SAMPLES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_s,
    input  logic              bsy_s,
    input  logic              sel_out,
    input  logic              io_s,
    input  logic [DATA_W-1:0] data_s,
    input  logic              par_s,
    input  logic [ID_W-1:0]   own_id,
    input  logic              sel_en,
    input  logic              resel_en,
    output logic              hit,
    output qual_kind_t        hit_kind,
    output logic [ID_W-1:0]   other_id,
    output logic              other_present
);

    logic [DATA_W-1:0] others;
    logic              own_set;
    logic              parity_ok;
    logic              bus_ok;
    int unsigned       n_others;
    qual_kind_t        kind;
    qual_kind_t        kind_q;
    logic [CNT_W-1:0]  run_cnt;

    // Mask the own bit out of the data byte, one bit per ID position.
    for (genvar b = 0; b < DATA_W; b++) begin : g_mask
        assign others[b] = data_s[b] & (own_id != ID_W'(b));
    end

    // Classify the current sample and encode the lowest other ID bit.
    always_comb begin
        own_set   = data_s[own_id];
        parity_ok = ^{data_s, par_s};
        bus_ok    = !sel_out && !bsy_s && sel_s && own_set && parity_ok;
        n_others  = $countones(others);
        other_id  = '0;
        for (int i = DATA_W - 1; i >= 0; i--) begin
            if (others[i]) other_id = ID_W'(i);
        end
        other_present = (n_others != 0);
        kind = QK_NONE;
        if (bus_ok && !io_s && sel_en && n_others <= 1)
            kind = QK_SEL;
        else if (bus_ok && io_s && resel_en && n_others == 1)
            kind = QK_RESEL;
    end

    // Count consecutive samples of the same non-idle kind.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kind_q  <= QK_NONE;
            run_cnt <= '0;
        end else begin
            kind_q <= kind;
            if (kind == QK_NONE)
                run_cnt <= '0;
            else if (kind == kind_q && run_cnt < CNT_W'(SAMPLES))
                run_cnt <= run_cnt + 1'b1;
            else if (kind != kind_q)
                run_cnt <= CNT_W'(1);
        end
    end

    assign hit      = (kind != QK_NONE) && (kind == kind_q)
                      && (run_cnt >= CNT_W'(SAMPLES - 1));
    assign hit_kind = kind;

endmodule

// File: rtl/scsi_sel_handshake.sv
// Sequencer for the BSY handshake after a qualified event. Loads the
// source ID register, drives BSY, waits for SEL release and raises the
// interrupt pulses. Assumes hit is only meaningful while idle; once a
// role is taken the sequencer stays there until reset.
module scsi_sel_handshake
    import scsi_sel_pkg::*;
#(
    parameter int ID_W  = 3,
    localparam int SRC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hit,
    input  qual_kind_t       hit_kind,
    input  logic [ID_W-1:0]  other_id,
    input  logic             other_present,
    input  logic             atn_s,
    input  logic             sel_s,
    output logic             bsy_out,
    output logic [SRC_W-1:0] src_id,
    output logic             irq_selected,
    output logic             irq_bus_service,
    output logic             irq_reselected
);

    hs_state_t state;
    logic      atn_seen;

    // State, BSY drive, captured ID and one-cycle interrupt pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state           <= ST_IDLE;
            bsy_out         <= 1'b0;
            src_id          <= {{(SRC_W-ID_W){1'b0}}, SRC_ID_RST_LOW};
            atn_seen        <= 1'b0;
            irq_selected    <= 1'b0;
            irq_bus_service <= 1'b0;
            irq_reselected  <= 1'b0;
        end else begin
            irq_selected    <= 1'b0;
            irq_bus_service <= 1'b0;
            irq_reselected  <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (hit && hit_kind != QK_NONE) begin
                        src_id <= '0;
                        src_id[SRC_W-1] <= other_present;
                        src_id[ID_W-1:0] <= other_present ? other_id : '0;
                        bsy_out  <= 1'b1;
                        atn_seen <= atn_s;
                        state    <= (hit_kind == QK_SEL) ? ST_SEL_HOLD
                                                         : ST_RESEL_HOLD;
                    end
                end
                ST_SEL_HOLD: begin
                    if (!sel_s) begin
                        irq_selected    <= 1'b1;
                        irq_bus_service <= atn_seen;
                        state           <= ST_TARGET;
                    end
                end
                ST_RESEL_HOLD: begin
                    if (!sel_s) begin
                        bsy_out        <= 1'b0;
                        irq_reselected <= 1'b1;
                        state          <= ST_INITIATOR;
                    end
                end
                ST_TARGET:    state <= ST_TARGET;
                ST_INITIATOR: state <= ST_INITIATOR;
                default:      state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/scsi_sel_responder.sv
// Top level: synchronizes the bus lines, qualifies selection and
// reselection of this device, and runs the BSY handshake. Assumes the
// enable bits and own ID are quasi-static configuration.
module scsi_sel_responder
    import scsi_sel_pkg::*;
#(
    parameter int ID_W        = 3,
    parameter int SYNC_STAGES = 2,
    parameter int QUAL_SAMPLES = 2,
    localparam int DATA_W     = 1 << ID_W,
    localparam int BUS_W      = DATA_W + 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_in,
    input  logic              bsy_in,
    input  logic              sel_out,
    input  logic              io_in,
    input  logic              atn_in,
    input  logic [DATA_W-1:0] data_in,
    input  logic              parity_in,
    input  logic [ID_W-1:0]   own_id,
    input  logic              sel_en,
    input  logic              resel_en,
    output logic              bsy_out,
    output logic [7:0]        src_id,
    output logic              irq_selected,
    output logic              irq_bus_service,
    output logic              irq_reselected
);

    logic [BUS_W-1:0]  bus_raw;
    logic [BUS_W-1:0]  bus_s;
    logic              sel_s, bsy_s, io_s, atn_s, par_s;
    logic [DATA_W-1:0] data_s;
    logic              hit;
    qual_kind_t        hit_kind;
    logic [ID_W-1:0]   other_id;
    logic              other_present;

    assign bus_raw = {sel_in, bsy_in, io_in, atn_in, parity_in, data_in};
    assign {sel_s, bsy_s, io_s, atn_s, par_s, data_s} = bus_s;

    scsi_bus_sync #(.WIDTH(BUS_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  (bus_raw),
        .d_out (bus_s)
    );

    scsi_sel_qualifier #(.ID_W(ID_W), .SAMPLES(QUAL_SAMPLES)) u_qual (
        .clk           (clk),
        .rst_n         (rst_n),
        .sel_s         (sel_s),
        .bsy_s         (bsy_s),
        .sel_out       (sel_out),
        .io_s          (io_s),
        .data_s        (data_s),
        .par_s         (par_s),
        .own_id        (own_id),
        .sel_en        (sel_en),
        .resel_en      (resel_en),
        .hit           (hit),
        .hit_kind      (hit_kind),
        .other_id      (other_id),
        .other_present (other_present)
    );

    scsi_sel_handshake #(.ID_W(ID_W)) u_hs (
        .clk             (clk),
        .rst_n           (rst_n),
        .hit             (hit),
        .hit_kind        (hit_kind),
        .other_id        (other_id),
        .other_present   (other_present),
        .atn_s           (atn_s),
        .sel_s           (sel_s),
        .bsy_out         (bsy_out),
        .src_id          (src_id),
        .irq_selected    (irq_selected),
        .irq_bus_service (irq_bus_service),
        .irq_reselected  (irq_reselected)
    );

endmodule

// File: rtl/scsi_sel_responder_chk.sv
// Property checker for the responder, attached by bind below.
module scsi_sel_responder_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       sel_en,
    input logic       resel_en,
    input logic       bsy_out,
    input logic [7:0] src_id,
    input logic       irq_selected,
    input logic       irq_bus_service,
    input logic       irq_reselected
);

    // R8/R9: the two role interrupts are mutually exclusive
    assert_one_role_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({irq_selected, irq_reselected}));

    assert_bus_service_with_sel_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_bus_service |-> irq_selected);

    assert_sel_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_selected |=> !irq_selected);

    assert_resel_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_reselected |=> !irq_reselected);

    assert_bsy_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_selected |-> bsy_out);

    assert_bsy_released_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_reselected |-> !bsy_out);

    assert_resel_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_reselected |-> src_id[7]);

    assert_bsy_needs_enable_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bsy_out) |-> $past(sel_en || resel_en));

    assert_connected_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(irq_selected) |-> (bsy_out && $stable(src_id)));

endmodule

bind scsi_sel_responder scsi_sel_responder_chk chk_i (
    .clk             (clk),
    .rst_n           (rst_n),
    .sel_en          (sel_en),
    .resel_en        (resel_en),
    .bsy_out         (bsy_out),
    .src_id          (src_id),
    .irq_selected    (irq_selected),
    .irq_bus_service (irq_bus_service),
    .irq_reselected  (irq_reselected)
);

// File: tb/scsi_sel_responder_tb_top.sv
module scsi_sel_responder_tb_top;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       sel_in, bsy_in, sel_out, io_in, atn_in, parity_in;
    logic [7:0] data_in;
    logic [2:0] own_id;
    logic       sel_en, resel_en;
    logic       bsy_out;
    logic [7:0] src_id;
    logic       irq_selected, irq_bus_service, irq_reselected;

    int checks = 0;
    int errors = 0;
    int n_irq  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    scsi_sel_responder dut_i (
        .clk(clk), .rst_n(rst_n), .sel_in(sel_in), .bsy_in(bsy_in),
        .sel_out(sel_out), .io_in(io_in), .atn_in(atn_in),
        .data_in(data_in), .parity_in(parity_in), .own_id(own_id),
        .sel_en(sel_en), .resel_en(resel_en), .bsy_out(bsy_out),
        .src_id(src_id), .irq_selected(irq_selected),
        .irq_bus_service(irq_bus_service), .irq_reselected(irq_reselected)
    );

    // Counts every interrupt pulse seen between clock edges.
    always @(negedge clk) begin
        if (rst_n && (irq_selected || irq_reselected || irq_bus_service))
            n_irq++;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Drive a bus pattern with odd parity unless bad_par is set.
    task automatic drive(input logic sel, input logic bsy, input logic so,
                         input logic io, input logic atn, input logic [7:0] d,
                         input logic bad_par);
        sel_in = sel; bsy_in = bsy; sel_out = so; io_in = io; atn_in = atn;
        data_in = d; parity_in = (~^d) ^ bad_par;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        drive(0, 0, 0, 0, 0, 8'h00, 0);
        own_id = 3'd3; sel_en = 1'b1; resel_en = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        n_irq = 0;
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 bsy", bsy_out, 0);
        chk("R1 src_id", src_id, 8'h07);
        chk("R1 irq", {irq_selected, irq_bus_service, irq_reselected}, 0);
    endtask

    // Apply a pattern and expect no response.
    task automatic t_reject(input string req, input logic sel, input logic bsy,
                            input logic so, input logic io, input logic [7:0] d,
                            input logic bad_par, input logic se, input logic re);
        do_reset();
        sel_en = se; resel_en = re;
        drive(sel, bsy, so, io, 0, d, bad_par);
        repeat (8) @(posedge clk);
        @(negedge clk);
        chk({req, " bsy"}, bsy_out, 0);
        chk({req, " src_id"}, src_id, 8'h07);
    endtask

    // Full selection: edge-accurate BSY rise and interrupt timing.
    task automatic t_select(input logic [7:0] d, input logic atn, input logic [7:0] exp_id);
        do_reset();
        drive(1, 0, 0, 0, atn, d, 0);
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R7 bsy not before E3", bsy_out, 0);
        @(posedge clk); @(negedge clk);
        chk("R7 bsy at E3", bsy_out, 1);
        chk("R6 src_id", src_id, {24'h0, exp_id});
        drive(0, 1, 0, 0, 0, 8'h00, 0);
        repeat (2) @(posedge clk); @(negedge clk);
        chk("R8 no irq early", irq_selected, 0);
        @(posedge clk); @(negedge clk);
        chk("R8 irq_selected", irq_selected, 1);
        chk("R8 bus service", irq_bus_service, atn);
        chk("R8 bsy held", bsy_out, 1);
        @(posedge clk); @(negedge clk);
        chk("R8 pulse one cycle", irq_selected, 0);
        chk("R8 bsy still held", bsy_out, 1);
    endtask

    task automatic t_reselect();
        do_reset();
        drive(1, 0, 0, 1, 0, 8'h0A, 0);
        repeat (4) @(posedge clk); @(negedge clk);
        chk("R3 bsy", bsy_out, 1);
        chk("R6 resel src_id", src_id, 8'h81);
        drive(0, 1, 0, 1, 0, 8'h00, 0);
        repeat (2) @(posedge clk); @(negedge clk);
        chk("R9 bsy before release", bsy_out, 1);
        @(posedge clk); @(negedge clk);
        chk("R9 irq_reselected", irq_reselected, 1);
        chk("R9 bsy released", bsy_out, 0);
        @(posedge clk); @(negedge clk);
        chk("R9 pulse one cycle", irq_reselected, 0);
    endtask

    task automatic t_glitch();
        do_reset();
        drive(1, 0, 0, 0, 0, 8'h48, 0);
        @(negedge clk);
        drive(0, 0, 0, 0, 0, 8'h00, 0);
        repeat (8) @(posedge clk); @(negedge clk);
        chk("R7 glitch bsy", bsy_out, 0);
        chk("R7 glitch src_id", src_id, 8'h07);
    endtask

    task automatic t_connected_ignores();
        t_select(8'h48, 1'b0, 8'h86);
        n_irq = 0;
        drive(1, 0, 0, 1, 0, 8'h0C, 0);
        repeat (10) @(posedge clk); @(negedge clk);
        chk("R10 src_id kept", src_id, 8'h86);
        chk("R10 bsy kept", bsy_out, 1);
        drive(0, 0, 0, 0, 0, 8'h00, 0);
        repeat (6) @(posedge clk); @(negedge clk);
        chk("R10 no irq", n_irq, 0);
    endtask

    initial begin
        t_reset();
        t_select(8'h48, 1'b0, 8'h86);
        t_select(8'h18, 1'b1, 8'h84);
        t_select(8'h08, 1'b0, 8'h00);
        t_reselect();
        t_reject("R2 sel_en off",   1, 0, 0, 0, 8'h48, 0, 0, 1);
        t_reject("R2 sel_out set",  1, 0, 1, 0, 8'h48, 0, 1, 1);
        t_reject("R2 bsy_in set",   1, 1, 0, 0, 8'h48, 0, 1, 1);
        t_reject("R2 sel_in low",   0, 0, 0, 0, 8'h48, 0, 1, 1);
        t_reject("R3 resel_en off", 1, 0, 0, 1, 8'h0A, 0, 1, 0);
        t_reject("R4 bad parity",   1, 0, 0, 0, 8'h48, 1, 1, 1);
        t_reject("R4 own bit clear", 1, 0, 0, 0, 8'h40, 0, 1, 1);
        t_reject("R5 sel two others", 1, 0, 0, 0, 8'h4A, 0, 1, 1);
        t_reject("R5 resel no other", 1, 0, 0, 1, 8'h08, 0, 1, 1);
        t_reject("R5 resel two others", 1, 0, 0, 1, 8'h4A, 0, 1, 1);
        t_glitch();
        t_connected_ignores();
        done = 1'b1;
    end

    initial begin
        for (int i = 0; i < 20000 && !done; i++) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected done");
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule